// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a register bus and a pair of audio serializers. It holds two word queues. One carries playback words from the bus towards the transmit serializer. The other carries capture words from the receive serializer back to the bus. Each queue is 32 words deep and 32 bits wide, and reports its fill count as a 6-bit level.

Software sets one threshold per direction. The transmit side reports "needs refill" while its level is low. The receive side reports "needs draining" while its level is high. The two threshold fields use different encodings: the transmit field holds the level itself, and the receive field holds the level minus one.

Two sticky error flags record misuse. The transmit flag records a pop from an empty queue. The receive flag records a push into a full queue. Each status bit has an enable, and the single interrupt output is raised while any enabled status bit is set. A per-direction flush command empties a queue over two cycles. The flush bit reads back as 1 while the flush runs.

Top module: `aud_fifo_irq`

## Requirements
- R1: After reset both levels are 0, the control readback is 0, the flush readback is 0 and the interrupt is low. The status word reads 0x1, because the transmit level 0 is at or below the reset threshold 0.
- R2: Each queue delivers words in the order they were accepted. Each queue holds up to 32 words, and its level output counts the stored words from 0 to 32. Read data is shown ahead: it is valid before the pop strobe.
- R3: A bus write to a full transmit queue is dropped. The level stays 32 and no status bit changes.
- R4: Status bit 0 (transmit-low) is 1 while the transmit level is less than or equal to control bits 8:4, which hold the threshold level directly.
- R5: Status bit 16 (receive-high) is 1 while the receive level is greater than or equal to control bits 24:20 plus one.
- R6: A serializer pop while the transmit queue is empty sets status bit 1 (underrun). The bit stays set until a control write with bit 2 set. It is visible one cycle after the pop.
- R7: A serializer push while the receive queue holds 32 words is dropped and sets status bit 17 (overrun). The queue contents are unchanged. The bit stays set until a control write with bit 18 set.
- R8: The interrupt is the OR of each status bit ANDed with its enable. The enables sit at control bits 0, 1, 16 and 17, matching status bits 0, 1, 16 and 17.
- R9: Writing 1 to flush bit 0 (transmit) or bit 1 (receive) makes that readback bit 1 for exactly two cycles after the write, then 0. The queue's level is 0 by the second of those cycles. Pushes and pops of that direction during the flush are ignored. The sticky flags and the other direction are not affected.
- R10: Control readback returns the stored thresholds and enables. The two clear bits (2 and 18) always read 0.
- R11: A flush write with a bit at 0 starts no flush for that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Bus write strobe into the transmit queue |
| tx_wdata | input | 32 | Bus write word |
| tx_pop | input | 1 | Transmit serializer takes the head word |
| tx_rdata | output | 32 | Head word of the transmit queue |
| rx_push | input | 1 | Receive serializer delivers a word |
| rx_wdata | input | 32 | Word from the receive serializer |
| rx_rd | input | 1 | Bus read strobe that removes the receive head word |
| rx_rdata | output | 32 | Head word of the receive queue |
| ctl_wr | input | 1 | Write strobe of the interrupt control word |
| ctl_wdata | input | 32 | Thresholds, enables and clear bits |
| ctl_rdata | output | 32 | Stored control word |
| flush_wr | input | 1 | Write strobe of the flush command |
| flush_wdata | input | 2 | Bit 0 flushes transmit, bit 1 flushes receive |
| flush_rdata | output | 2 | Flush in progress per direction |
| tx_level | output | 6 | Transmit fill level |
| rx_level | output | 6 | Receive fill level |
| status | output | 32 | Raw status word (bits 0, 1, 16, 17) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench pushes both queues to exactly 32 words and then one more. A design that wrapped its pointers would lose data or corrupt the word order, and one that mis-set the flags would raise the wrong flag on the transmit side or miss overrun on the receive side. It walks each threshold across its edge: at level 4 against 5 on the transmit side, and at 3 against 4 on the receive side with field value 3. An off-by-one in either encoding, or the two encodings swapped, shows up there. It holds sticky flags across idle cycles and a flush, and checks that the interrupt masks through the enables. It also samples the flush readback on each of its cycles while pushing data into the flushed queue. A flush of the wrong length, or one that let a write through, leaves a wrong level or a stale word.

// File: rtl/afq_pkg.sv
package afq_pkg;

    localparam int REG_W       = 32;
    localparam int THR_W       = 5;
    localparam int TX_THR_LSB  = 4;
    localparam int RX_THR_LSB  = 20;
    localparam int BIT_TXE     = 0;
    localparam int BIT_TXU     = 1;
    localparam int BIT_TXU_CLR = 2;
    localparam int BIT_RXF     = 16;
    localparam int BIT_RXO     = 17;
    localparam int BIT_RXO_CLR = 18;
    localparam int DIR_TX      = 0;
    localparam int DIR_RX      = 1;
    localparam int NUM_DIR     = 2;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr_m1;
        logic             en_txe;
        logic             en_txu;
        logic             en_rxf;
        logic             en_rxo;
    } ctl_t;

    typedef struct packed {
        logic txe;
        logic txu;
        logic rxf;
        logic rxo;
    } stat_t;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_FIRST = 2'd1,
        FL_LAST  = 2'd2
    } flush_state_e;

    function automatic ctl_t ctl_decode(input logic [REG_W-1:0] w);
        ctl_t c;
        c.tx_thr    = w[TX_THR_LSB +: THR_W];
        c.rx_thr_m1 = w[RX_THR_LSB +: THR_W];
        c.en_txe    = w[BIT_TXE];
        c.en_txu    = w[BIT_TXU];
        c.en_rxf    = w[BIT_RXF];
        c.en_rxo    = w[BIT_RXO];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_encode(input ctl_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[TX_THR_LSB +: THR_W] = c.tx_thr;
        r[RX_THR_LSB +: THR_W] = c.rx_thr_m1;
        r[BIT_TXE] = c.en_txe;
        r[BIT_TXU] = c.en_txu;
        r[BIT_RXF] = c.en_rxf;
        r[BIT_RXO] = c.en_rxo;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] stat_encode(input stat_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[BIT_TXE] = s.txe;
        r[BIT_TXU] = s.txu;
        r[BIT_RXF] = s.rxf;
        r[BIT_RXO] = s.rxo;
        return r;
    endfunction

    function automatic stat_t stat_mask(input stat_t s, input ctl_t c);
        stat_t m;
        m.txe = s.txe & c.en_txe;
        m.txu = s.txu & c.en_txu;
        m.rxf = s.rxf & c.en_rxf;
        m.rxo = s.rxo & c.en_rxo;
        return m;
    endfunction

endpackage

// File: rtl/afq_fifo.sv
module afq_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [LW-1:0] level,
    output logic          drop,
    output logic          starve
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, acc_wr, acc_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (level == LW'(DEPTH));
    assign empty  = (level == '0);
    assign acc_wr = wr_en & ~full & ~clr;
    assign acc_rd = rd_en & ~empty & ~clr;
    assign drop   = wr_en & full & ~clr;
    assign starve = rd_en & empty & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (acc_wr) wp <= bump(wp);
            if (acc_rd) rp <= bump(rp);
            level <= level + LW'(acc_wr) - LW'(acc_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (acc_wr) mem[wp] <= wr_data;
    end

    assign rd_data = mem[rp];

    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    a_r3_full_hold: assert property (@(posedge clk) disable iff (rst)
        full && wr_en && !rd_en && !clr |=> level == LW'(DEPTH));

    a_r9_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> level == '0);

endmodule

// File: rtl/afq_flush.sv
module afq_flush (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy
);
    import afq_pkg::*;

    flush_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FL_IDLE;
        end else begin
            unique case (st)
                FL_IDLE:  if (req) st <= FL_FIRST;
                FL_FIRST: st <= FL_LAST;
                default:  st <= FL_IDLE;
            endcase
        end
    end

    assign busy = (st != FL_IDLE);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    a_r9_busy_ends: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |=> !busy);

    a_r11_no_req_idle: assert property (@(posedge clk) disable iff (rst)
        !busy && !req |=> !busy);

endmodule

// File: rtl/afq_irq.sv
module afq_irq #(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic          tx_starve,
    input  logic          rx_drop,
    output logic [31:0]   ctl_rdata,
    output logic [31:0]   stat_word,
    output logic          irq
);
    import afq_pkg::*;

    ctl_t  ctl_q;
    stat_t st, act;
    logic  txu_q, rxo_q, clr_u, clr_o;
    logic  unused_wbits;

    assign unused_wbits = ^ctl_wdata;
    assign clr_u = ctl_wr & ctl_wdata[BIT_TXU_CLR];
    assign clr_o = ctl_wr & ctl_wdata[BIT_RXO_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            txu_q <= 1'b0;
            rxo_q <= 1'b0;
        end else begin
            if (ctl_wr) ctl_q <= ctl_decode(ctl_wdata);
            txu_q <= tx_starve | (txu_q & ~clr_u);
            rxo_q <= rx_drop | (rxo_q & ~clr_o);
        end
    end

    always_comb begin
        st.txe = (tx_level <= LW'(ctl_q.tx_thr));
        st.rxf = (rx_level >= LW'(ctl_q.rx_thr_m1) + LW'(1));
        st.txu = txu_q;
        st.rxo = rxo_q;
        act    = stat_mask(st, ctl_q);
    end

    assign irq       = |act;
    assign stat_word = stat_encode(st);
    assign ctl_rdata = ctl_encode(ctl_q);

    a_r6_txu_sets: assert property (@(posedge clk) disable iff (rst)
        tx_starve |=> stat_word[BIT_TXU]);

    a_r6_txu_sticky: assert property (@(posedge clk) disable iff (rst)
        stat_word[BIT_TXU] && !clr_u |=> stat_word[BIT_TXU]);

    a_r7_rxo_sets: assert property (@(posedge clk) disable iff (rst)
        rx_drop |=> stat_word[BIT_RXO]);

    a_r7_rxo_sticky: assert property (@(posedge clk) disable iff (rst)
        stat_word[BIT_RXO] && !clr_o |=> stat_word[BIT_RXO]);

    a_r5_rxf_empty: assert property (@(posedge clk) disable iff (rst)
        rx_level == '0 |-> !stat_word[BIT_RXF]);

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[BIT_TXE] | ctl_rdata[BIT_TXU] | ctl_rdata[BIT_RXF] | ctl_rdata[BIT_RXO]) == 1'b0 |-> !irq);

    a_r10_clr_bits_zero: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[BIT_TXU_CLR] && !ctl_rdata[BIT_RXO_CLR]);

endmodule

// File: rtl/aud_fifo_irq.sv
module aud_fifo_irq #(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 32,
    localparam int LW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              flush_wr,
    input  logic [1:0]        flush_wdata,
    output logic [1:0]        flush_rdata,
    output logic [LW-1:0]     tx_level,
    output logic [LW-1:0]     rx_level,
    output logic [31:0]       status,
    output logic              irq
);
    import afq_pkg::*;

    logic [NUM_DIR-1:0] fl_busy;
    logic tx_drop_unused, tx_starve, rx_drop, rx_starve_unused;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_flush
        afq_flush u_fl (
            .clk  (clk),
            .rst  (rst),
            .req  (flush_wr & flush_wdata[d]),
            .busy (fl_busy[d])
        );
    end

    assign flush_rdata = fl_busy;

    afq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .clr     (fl_busy[DIR_TX]),
        .wr_en   (tx_wr),
        .wr_data (tx_wdata),
        .rd_en   (tx_pop),
        .rd_data (tx_rdata),
        .level   (tx_level),
        .drop    (tx_drop_unused),
        .starve  (tx_starve)
    );

    afq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .clr     (fl_busy[DIR_RX]),
        .wr_en   (rx_push),
        .wr_data (rx_wdata),
        .rd_en   (rx_rd),
        .rd_data (rx_rdata),
        .level   (rx_level),
        .drop    (rx_drop),
        .starve  (rx_starve_unused)
    );

    afq_irq #(.LW(LW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_starve (tx_starve),
        .rx_drop   (rx_drop),
        .ctl_rdata (ctl_rdata),
        .stat_word (status),
        .irq       (irq)
    );

endmodule

// File: tb/sim_aud_fifo_irq.sv
module sim_aud_fifo_irq;

    localparam int NDEEP = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0, ctl_wr = 0, flush_wr = 0;
    logic [31:0] tx_wdata = 0, rx_wdata = 0, ctl_wdata = 0;
    logic [1:0]  flush_wdata = 0;
    logic [31:0] tx_rdata, rx_rdata, ctl_rdata, status;
    logic [1:0]  flush_rdata;
    logic [5:0]  tx_level, rx_level;
    logic        irq;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    bit          tx_hold = 0, rx_hold = 0;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    aud_fifo_irq u0 (
        .clk(clk), .rst(rst),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .flush_wr(flush_wr), .flush_wdata(flush_wdata), .flush_rdata(flush_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .status(status), .irq(irq)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares the head word whenever a pop or read is presented
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            if (tx_pop && !tx_hold && txq.size() > 0) chk_eq("R2 tx order", tx_rdata, txq.pop_front());
            if (rx_rd && !rx_hold && rxq.size() > 0) chk_eq("R2 rx order", rx_rdata, rxq.pop_front());
        end
    end

    task automatic tx_put(input logic [31:0] d);
        tx_wr = 1; tx_wdata = d;
        if (!tx_hold && txq.size() < NDEEP) txq.push_back(d);
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic tx_take();
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic rx_feed(input logic [31:0] d);
        rx_push = 1; rx_wdata = d;
        if (!rx_hold && rxq.size() < NDEEP) rxq.push_back(d);
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic rx_get();
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
    endtask

    task automatic ctl_put(input logic [31:0] v);
        ctl_wr = 1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // flush with pushes presented on the flushed side during both busy cycles (R9)
    task automatic flush_seq(input logic [1:0] v);
        flush_wr = 1; flush_wdata = v;
        if (v[0]) begin txq.delete(); tx_hold = 1; end
        if (v[1]) begin rxq.delete(); rx_hold = 1; end
        @(negedge clk);
        flush_wr = 0;
        chk_eq("R9 flush busy first cycle", {30'd0, flush_rdata}, {30'd0, v});
        if (v[0]) tx_put(32'hF00D_0001);
        if (v[1]) rx_feed(32'hF00D_0002);
        if (v == 2'b00) @(negedge clk);
        chk_eq("R9 flush busy second cycle", {30'd0, flush_rdata}, {30'd0, v});
        if (v[0]) chk_eq("R9 tx level zero", {26'd0, tx_level}, 32'd0);
        if (v[1]) chk_eq("R9 rx level zero", {26'd0, rx_level}, 32'd0);
        if (v[0]) tx_put(32'hF00D_0003);
        if (v[1]) rx_feed(32'hF00D_0004);
        if (v == 2'b00) @(negedge clk);
        chk_eq("R9 flush done", {30'd0, flush_rdata}, 32'd0);
        if (v[0]) chk_eq("R9 tx write ignored", {26'd0, tx_level}, 32'd0);
        if (v[1]) chk_eq("R9 rx write ignored", {26'd0, rx_level}, 32'd0);
        tx_hold = 0; rx_hold = 0;
    endtask

    localparam logic [31:0] CTL_A = (32'd4 << 4) | (32'd3 << 20) | 32'h0003_0003;
    localparam logic [31:0] FIELDS = (32'd4 << 4) | (32'd3 << 20);

    initial begin
        #(200000 * 8);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_eq("R1 tx level", {26'd0, tx_level}, 32'd0);
        chk_eq("R1 rx level", {26'd0, rx_level}, 32'd0);
        chk_eq("R1 ctl", ctl_rdata, 32'd0);
        chk_eq("R1 flush", {30'd0, flush_rdata}, 32'd0);
        chk_eq("R1 status", status, 32'h1);
        chk_eq("R1 irq", {31'd0, irq}, 32'd0);

        // R10 readback, R8 enabled transmit-low
        ctl_put(CTL_A);
        chk_eq("R10 ctl readback", ctl_rdata, CTL_A);
        chk_eq("R8 irq txe", {31'd0, irq}, 32'd1);

        // R4 threshold edge at 4
        for (int i = 0; i < 4; i++) tx_put(32'h1000 + i);
        chk_eq("R4 level 4 at threshold", status, 32'h1);
        tx_put(32'h1004);
        chk_eq("R4 level 5 above threshold", status, 32'h0);
        chk_eq("R8 irq low", {31'd0, irq}, 32'd0);

        // R2/R3 fill and overfill
        for (int i = 5; i < NDEEP; i++) tx_put(32'h1000 + i);
        chk_eq("R2 tx level full", {26'd0, tx_level}, 32'd32);
        tx_put(32'hDEAD_0000);
        chk_eq("R3 tx level stays", {26'd0, tx_level}, 32'd32);
        chk_eq("R3 no flag", status, 32'h0);

        for (int i = 0; i < 28; i++) tx_take();
        chk_eq("R4 back to threshold", status, 32'h1);
        for (int i = 0; i < 4; i++) tx_take();
        chk_eq("R2 tx empty", {26'd0, tx_level}, 32'd0);

        // R6 underrun
        tx_take();
        chk_eq("R6 underrun set", status, 32'h3);
        idle(3);
        chk_eq("R6 underrun sticky", status, 32'h3);
        ctl_put(CTL_A | 32'h4);
        chk_eq("R6 underrun cleared", status, 32'h1);
        chk_eq("R10 clear bit reads 0", ctl_rdata, CTL_A);

        // R5 receive threshold field 3 -> level 4
        for (int i = 0; i < 3; i++) rx_feed(32'h2000 + i);
        chk_eq("R5 level 3 below", status, 32'h1);
        rx_feed(32'h2003);
        chk_eq("R5 level 4 at", status, 32'h0001_0001);

        // R7 overrun
        for (int i = 4; i < NDEEP; i++) rx_feed(32'h2000 + i);
        rx_feed(32'hBEEF_0000);
        chk_eq("R7 rx level stays", {26'd0, rx_level}, 32'd32);
        chk_eq("R7 overrun set", status, 32'h0003_0001);
        for (int i = 0; i < NDEEP; i++) rx_get();
        chk_eq("R7 overrun sticky", status, 32'h0002_0001);

        // R8 masking
        ctl_put(FIELDS | 32'h0002_0000);
        chk_eq("R8 irq by overrun only", {31'd0, irq}, 32'd1);
        ctl_put(FIELDS);
        chk_eq("R8 irq masked", {31'd0, irq}, 32'd0);
        chk_eq("R8 status unmasked", status, 32'h0002_0001);
        ctl_put(CTL_A | 32'h0004_0000);
        chk_eq("R7 overrun cleared", status, 32'h1);

        // R9 flush transmit keeps sticky and leaves receive alone
        tx_take();
        for (int i = 0; i < 3; i++) tx_put(32'h3000 + i);
        rx_feed(32'h4000); rx_feed(32'h4001);
        flush_seq(2'b01);
        chk_eq("R9 sticky kept", status, 32'h3);
        chk_eq("R9 rx untouched", {26'd0, rx_level}, 32'd2);
        tx_put(32'h5000);
        flush_seq(2'b10);
        chk_eq("R9 tx untouched", {26'd0, tx_level}, 32'd1);

        // R11 zero flush bits
        flush_seq(2'b00);
        chk_eq("R11 tx level kept", {26'd0, tx_level}, 32'd1);
        tx_take();
        chk_eq("R2 tx drained", {26'd0, tx_level}, 32'd0);
        idle(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule